// File: doc/BRIEF.md
# Overcurrent Fault Response Sequencer

This block is the digital side of per-channel overcurrent handling in a buck converter controller. Once per switching period an analog comparator reports whether the sensed inductor current crossed the fault threshold, and a second comparator reports the same for a lower warning threshold. The block uses these results in three ways. It truncates the high-side on-time in any period that is over the limit. It declares a fault when the fault condition persists for three periods in a row. It then either shuts the channel down until software steps in, or runs an automatic retry loop that sits out seven soft-start periods before restarting.

Each channel has its own state machine with five states. `ST_OFF` means the channel is disabled. `ST_SOFT` means soft-start is in progress with the gates enabled. `ST_RUN` is normal switching. `ST_HICCUP` means the gates are off while soft-start periods are counted. `ST_LATCH` means the gates are off until released.

The named transitions are:
- *enable* (`ST_OFF`→`ST_SOFT`)
- *ramp_done* (`ST_SOFT`→`ST_RUN` on a soft-start-done strobe)
- *trip_hiccup* (`ST_SOFT`/`ST_RUN`→`ST_HICCUP` when a fault trips and hiccup is selected)
- *trip_latch* (`ST_SOFT`/`ST_RUN`→`ST_LATCH` when a fault trips and latch-off is selected)
- *retry* (`ST_HICCUP`→`ST_SOFT` after the seventh soft-start-done strobe)
- *release* (`ST_LATCH`→`ST_SOFT` on a clear pulse)
- *disable* (any state→`ST_OFF` when the enable is low)

A small sharing stage passes the fault and warning limit codes on to the analog threshold generators. In two-phase mode every channel receives channel 0's codes. In dual-output mode each channel keeps its own codes.

Top module: `oc_fault_seq`

## Requirements
- R1: After reset, all gate enables, truncation and soft-start requests are 0, and both status bits are 0 on every channel.
- R2: When a channel's enable is high in `ST_OFF`, the channel is in `ST_SOFT` one clock later, with `ss_req`, `hs_en` and `ls_en` at 1. A soft-start-done strobe moves it to `ST_RUN`, where `ss_req` is 0 and the gates stay on.
- R3: `hs_trunc` is 1 in exactly those cycles in which the gates are on and `oc_flag` is 1. It is 0 while the gates are off.
- R4: A fault trips on the third consecutive switching strobe, with the gates on, that samples `oc_flag`=1. A strobe with `oc_flag`=0 resets the count to zero. One clock after the tripping strobe, `hs_en` and `ls_en` are 0. Other channels are unaffected.
- R5: With `resp_hiccup`=0 (latch-off), the channel stays with its gates off and `ss_req`=0 until either a `clr_flt` pulse or an enable low-then-high. Soft-start-done strobes and switching strobes in between are ignored. Either release restarts at `ST_SOFT` with a zero consecutive count.
- R6: With `resp_hiccup`=1 (hiccup), the gates are off and `ss_req`=1 after the trip. The first six soft-start-done strobes leave the gates off. The seventh returns the channel to `ST_SOFT` with the gates on.
- R7: If overcurrent persists after a hiccup restart, three more consecutive overcurrent strobes trip the fault again and repeat the hiccup. If overcurrent has gone, the channel reaches `ST_RUN` and keeps switching.
- R8: `flt_sts` is set by a trip and stays set, including after a successful retry, until `clr_flt`. If a trip and `clr_flt` fall in the same cycle, the bit ends up set.
- R9: A switching strobe with the gates on and `ocw_flag`=1 sets the sticky `warn_sts` without turning the gates off. `clr_flt` clears it.
- R10: With `two_phase`=0, each channel's limit outputs equal its own limit inputs. With `two_phase`=1, every channel's limit outputs equal channel 0's inputs. Channel c occupies bits [c*LIM_W +: LIM_W].
- R11: An enable at 0 puts the channel in `ST_OFF` one clock later from any state, with the gates off and `ss_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NCH | Per-channel enable |
| clr_flt | input | 1 | Clear-faults pulse, shared by all channels |
| two_phase | input | 1 | 1 = both channels share channel 0's limits |
| resp_hiccup | input | NCH | Fault response: 0 latch-off, 1 hiccup |
| cyc_stb | input | NCH | One-clock strobe per switching period |
| oc_flag | input | NCH | Fault comparator output |
| ocw_flag | input | NCH | Warning comparator output |
| ss_done | input | NCH | One-clock strobe at the end of a soft-start period |
| oc_lim_in | input | NCH*LIM_W | Per-channel fault limit codes |
| warn_lim_in | input | NCH*LIM_W | Per-channel warning limit codes |
| oc_lim_out | output | NCH*LIM_W | Fault limit codes sent to the threshold generators |
| warn_lim_out | output | NCH*LIM_W | Warning limit codes sent to the threshold generators |
| hs_en | output | NCH | High-side gate enable |
| ls_en | output | NCH | Low-side gate enable |
| hs_trunc | output | NCH | Ends the present high-side on-time |
| ss_req | output | NCH | Soft-start ramp request |
| flt_sts | output | NCH | Sticky overcurrent fault status |
| warn_sts | output | NCH | Sticky overcurrent warning status |

## Verification
The clear-faults pulse and the third consecutive overcurrent strobe can land on the same clock edge, so the sticky fault bit could be cleared and set at once. The bench runs a channel with two overcurrent strobes, then drives the third strobe together with `clr_flt` in the same cycle. It expects `flt_sts` to read 1 and the gates to be off one clock later. A following lone clear must then drop the bit to 0.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_SOFT   = 3'd1,
        ST_RUN    = 3'd2,
        ST_HICCUP = 3'd3,
        ST_LATCH  = 3'd4
    } oc_state_e;

    typedef enum logic {
        RESP_LATCH  = 1'b0,
        RESP_HICCUP = 1'b1
    } oc_resp_e;

endpackage

// File: rtl/oc_run_counter.sv
// Counts consecutive over-limit switching periods while the gates are on.
module oc_run_counter #(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic stb,
    input  logic oc,
    output logic trip
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt;

    assign trip = arm && stb && oc && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm) begin
            cnt <= '0;
        end else if (stb) begin
            if (!oc || trip) cnt <= '0;
            else             cnt <= cnt + CNT_W'(1);
        end
    end

    // R4: the run count never reaches the trip length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(RUN_LEN));

    // R4: a clean period empties the count
    p_clean_resets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !oc) |=> (cnt == '0));

endmodule

// File: rtl/oc_hiccup_timer.sv
// Counts soft-start periods while the channel sits out a hiccup.
module oc_hiccup_timer #(
    parameter int HICCUP_N = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    output logic done
);
    localparam int HC_W = $clog2(HICCUP_N + 1);
    localparam logic [HC_W-1:0] LAST = HC_W'(HICCUP_N - 1);

    logic [HC_W-1:0] cnt;

    assign done = arm && tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + HC_W'(1);
        end
    end

    // R6: the period count stays below the hiccup length
    p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < HC_W'(HICCUP_N));

    // R6: leaving the hiccup empties the count
    p_timer_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (cnt == '0));

endmodule

// File: rtl/oc_lim_share.sv
// Passes limit codes through, or fans channel 0's codes out in two-phase mode.
module oc_lim_share #(
    parameter int NCH   = 2,
    parameter int LIM_W = 8
) (
    input  logic                   two_phase,
    input  logic [NCH*LIM_W-1:0]   oc_lim_in,
    input  logic [NCH*LIM_W-1:0]   warn_lim_in,
    output logic [NCH*LIM_W-1:0]   oc_lim_out,
    output logic [NCH*LIM_W-1:0]   warn_lim_out
);
    for (genvar c = 0; c < NCH; c++) begin : g_lim
        assign oc_lim_out[c*LIM_W +: LIM_W] =
            two_phase ? oc_lim_in[LIM_W-1:0] : oc_lim_in[c*LIM_W +: LIM_W];
        assign warn_lim_out[c*LIM_W +: LIM_W] =
            two_phase ? warn_lim_in[LIM_W-1:0] : warn_lim_in[c*LIM_W +: LIM_W];
    end

endmodule

// File: rtl/oc_chan_ctrl.sv
// Per-channel state machine, gate outputs and sticky status.
module oc_chan_ctrl
    import oc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic clr_flt,
    input  logic resp_hiccup,
    input  logic cyc_stb,
    input  logic oc_flag,
    input  logic ocw_flag,
    input  logic ss_done,
    input  logic trip,
    input  logic hic_done,
    output logic gate_on,
    output logic in_hiccup,
    output logic hs_en,
    output logic ls_en,
    output logic hs_trunc,
    output logic ss_req,
    output logic flt_sts,
    output logic warn_sts
);
    oc_state_e state, nxt;
    oc_resp_e  resp;
    logic      warn_ev;

    assign resp    = oc_resp_e'(resp_hiccup);
    assign warn_ev = gate_on && cyc_stb && ocw_flag;

    // next-state logic
    always_comb begin
        nxt = state;
        if (!chan_en) begin
            nxt = ST_OFF;                                   // disable
        end else begin
            unique case (state)
                ST_OFF:    nxt = ST_SOFT;                   // enable
                ST_SOFT, ST_RUN: begin
                    if (trip)
                        nxt = (resp == RESP_HICCUP) ? ST_HICCUP : ST_LATCH;
                    else if (state == ST_SOFT && ss_done)
                        nxt = ST_RUN;                       // ramp_done
                end
                ST_HICCUP: if (hic_done) nxt = ST_SOFT;     // retry
                ST_LATCH:  if (clr_flt)  nxt = ST_SOFT;     // release
                default:   nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // outputs decoded from state
    always_comb begin
        gate_on   = 1'b0;
        ss_req    = 1'b0;
        in_hiccup = 1'b0;
        unique case (state)
            ST_OFF:    ;
            ST_SOFT:   begin gate_on = 1'b1; ss_req = 1'b1; end
            ST_RUN:    gate_on = 1'b1;
            ST_HICCUP: begin ss_req = 1'b1; in_hiccup = 1'b1; end
            ST_LATCH:  ;
            default:   ;
        endcase
    end

    assign hs_en    = gate_on;
    assign ls_en    = gate_on;
    assign hs_trunc = gate_on && oc_flag;

    // sticky status: a set in the same cycle beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_sts  <= 1'b0;
            warn_sts <= 1'b0;
        end else begin
            if (trip)         flt_sts <= 1'b1;
            else if (clr_flt) flt_sts <= 1'b0;
            if (warn_ev)      warn_sts <= 1'b1;
            else if (clr_flt) warn_sts <= 1'b0;
        end
    end

    // R4: a trip removes both gate drives on the next clock
    p_trip_gates_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (!hs_en && !ls_en));

    // R5: latch-off holds without a release
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && chan_en && !clr_flt) |=> (state == ST_LATCH));

    // R5: a clear releases the latch into soft-start
    p_latch_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && chan_en && clr_flt) |=> (state == ST_SOFT));

    // R6: the end of the hiccup window restarts soft-start
    p_hiccup_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hic_done && chan_en) |=> (state == ST_SOFT && hs_en));

    // R8: the fault bit is sticky until a clear
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_sts && !clr_flt) |=> flt_sts);

    // R8: a trip always leaves the bit set, even with a clear in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> flt_sts);

    // R9: a warning alone never shuts the gates
    p_warn_keeps_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_ev && !trip && chan_en) |=> gate_on);

    // R11: disable reaches the off state in one clock
    p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (state == ST_OFF && !ss_req));

endmodule

// File: rtl/oc_fault_seq.sv
// Top: one sequencer per channel plus limit sharing.
module oc_fault_seq #(
    parameter int NCH      = 2,
    parameter int LIM_W    = 8,
    parameter int RUN_LEN  = 3,
    parameter int HICCUP_N = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       chan_en,
    input  logic                 clr_flt,
    input  logic                 two_phase,
    input  logic [NCH-1:0]       resp_hiccup,
    input  logic [NCH-1:0]       cyc_stb,
    input  logic [NCH-1:0]       oc_flag,
    input  logic [NCH-1:0]       ocw_flag,
    input  logic [NCH-1:0]       ss_done,
    input  logic [NCH*LIM_W-1:0] oc_lim_in,
    input  logic [NCH*LIM_W-1:0] warn_lim_in,
    output logic [NCH*LIM_W-1:0] oc_lim_out,
    output logic [NCH*LIM_W-1:0] warn_lim_out,
    output logic [NCH-1:0]       hs_en,
    output logic [NCH-1:0]       ls_en,
    output logic [NCH-1:0]       hs_trunc,
    output logic [NCH-1:0]       ss_req,
    output logic [NCH-1:0]       flt_sts,
    output logic [NCH-1:0]       warn_sts
);
    logic [NCH-1:0] gate_on;
    logic [NCH-1:0] in_hiccup;
    logic [NCH-1:0] trip;
    logic [NCH-1:0] hic_done;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        oc_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (gate_on[c]),
            .stb   (cyc_stb[c]),
            .oc    (oc_flag[c]),
            .trip  (trip[c])
        );

        oc_hiccup_timer #(.HICCUP_N(HICCUP_N)) u_hic (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (in_hiccup[c]),
            .tick  (ss_done[c]),
            .done  (hic_done[c])
        );

        oc_chan_ctrl u_ctrl (
            .clk         (clk),
            .rst_n       (rst_n),
            .chan_en     (chan_en[c]),
            .clr_flt     (clr_flt),
            .resp_hiccup (resp_hiccup[c]),
            .cyc_stb     (cyc_stb[c]),
            .oc_flag     (oc_flag[c]),
            .ocw_flag    (ocw_flag[c]),
            .ss_done     (ss_done[c]),
            .trip        (trip[c]),
            .hic_done    (hic_done[c]),
            .gate_on     (gate_on[c]),
            .in_hiccup   (in_hiccup[c]),
            .hs_en       (hs_en[c]),
            .ls_en       (ls_en[c]),
            .hs_trunc    (hs_trunc[c]),
            .ss_req      (ss_req[c]),
            .flt_sts     (flt_sts[c]),
            .warn_sts    (warn_sts[c])
        );

        // R3: truncation is only issued while the channel is switching
        p_trunc_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
            hs_trunc[c] |-> (hs_en[c] && ls_en[c]));
    end

    oc_lim_share #(.NCH(NCH), .LIM_W(LIM_W)) u_lim (
        .two_phase    (two_phase),
        .oc_lim_in    (oc_lim_in),
        .warn_lim_in  (warn_lim_in),
        .oc_lim_out   (oc_lim_out),
        .warn_lim_out (warn_lim_out)
    );

endmodule

// File: tb/tb_oc_fault_seq.sv
module tb_oc_fault_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 2;
    localparam int LIM_W = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH-1:0]       chan_en = '0;
    logic                 clr_flt = 1'b0;
    logic                 two_phase = 1'b0;
    logic [NCH-1:0]       resp_hiccup = '0;
    logic [NCH-1:0]       cyc_stb = '0;
    logic [NCH-1:0]       oc_flag = '0;
    logic [NCH-1:0]       ocw_flag = '0;
    logic [NCH-1:0]       ss_done = '0;
    logic [NCH*LIM_W-1:0] oc_lim_in = '0;
    logic [NCH*LIM_W-1:0] warn_lim_in = '0;
    logic [NCH*LIM_W-1:0] oc_lim_out, warn_lim_out;
    logic [NCH-1:0]       hs_en, ls_en, hs_trunc, ss_req, flt_sts, warn_sts;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_fault_seq #(.NCH(NCH), .LIM_W(LIM_W)) dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .clr_flt(clr_flt),
        .two_phase(two_phase), .resp_hiccup(resp_hiccup), .cyc_stb(cyc_stb),
        .oc_flag(oc_flag), .ocw_flag(ocw_flag), .ss_done(ss_done),
        .oc_lim_in(oc_lim_in), .warn_lim_in(warn_lim_in),
        .oc_lim_out(oc_lim_out), .warn_lim_out(warn_lim_out),
        .hs_en(hs_en), .ls_en(ls_en), .hs_trunc(hs_trunc), .ss_req(ss_req),
        .flt_sts(flt_sts), .warn_sts(warn_sts)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one switching period strobe
    task automatic cyc(input int ch, input logic oc, input logic w);
        @(negedge clk);
        cyc_stb[ch] = 1'b1; oc_flag[ch] = oc; ocw_flag[ch] = w;
        @(negedge clk);
        cyc_stb[ch] = 1'b0; oc_flag[ch] = 1'b0; ocw_flag[ch] = 1'b0;
    endtask

    task automatic ssdone(input int ch);
        @(negedge clk); ss_done[ch] = 1'b1;
        @(negedge clk); ss_done[ch] = 1'b0;
    endtask

    task automatic clear_pulse();
        @(negedge clk); clr_flt = 1'b1;
        @(negedge clk); clr_flt = 1'b0;
    endtask

    // reset the channel to ST_RUN with clean status
    task automatic bring_up(input int ch);
        @(negedge clk); chan_en[ch] = 1'b0; clr_flt = 1'b1;
        @(negedge clk); clr_flt = 1'b0; chan_en[ch] = 1'b1;
        @(negedge clk);
        ssdone(ch);
    endtask

    task automatic t_reset();
        chk("R1 hs_en", 32'(hs_en), 0);
        chk("R1 ls_en", 32'(ls_en), 0);
        chk("R1 ss_req", 32'(ss_req), 0);
        chk("R1 trunc", 32'(hs_trunc), 0);
        chk("R1 status", 32'({flt_sts, warn_sts}), 0);
    endtask

    task automatic t_startup();
        @(negedge clk); chan_en = 2'b11;
        @(negedge clk);
        chk("R2 ss_req soft", 32'(ss_req), 32'h3);
        chk("R2 gates soft", 32'({hs_en, ls_en}), 32'hF);
        ssdone(0); ssdone(1);
        chk("R2 ss_req run", 32'(ss_req), 0);
        chk("R2 gates run", 32'(hs_en), 32'h3);
    endtask

    task automatic t_trunc();
        @(negedge clk); oc_flag[0] = 1'b1;
        #1 chk("R3 trunc on", 32'(hs_trunc[0]), 1);
        chk("R3 trunc ch1", 32'(hs_trunc[1]), 0);
        @(negedge clk); oc_flag[0] = 1'b0;
        #1 chk("R3 trunc off", 32'(hs_trunc[0]), 0);
    endtask

    task automatic t_latch();
        resp_hiccup[0] = 1'b0;
        bring_up(0);
        cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 0, 0); cyc(0, 1, 0); cyc(0, 1, 0);
        chk("R4 broken run no trip", 32'(hs_en[0]), 1);
        chk("R4 broken run no flag", 32'(flt_sts[0]), 0);
        cyc(0, 1, 0);
        chk("R4 third trips hs", 32'(hs_en[0]), 0);
        chk("R4 third trips ls", 32'(ls_en[0]), 0);
        chk("R4 other channel", 32'(hs_en[1]), 1);
        chk("R8 flag set", 32'(flt_sts[0]), 1);
        ssdone(0); ssdone(0); ssdone(0);
        cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
        chk("R5 latched hs", 32'(hs_en[0]), 0);
        chk("R5 latched ss_req", 32'(ss_req[0]), 0);
        @(negedge clk); oc_flag[0] = 1'b1;
        #1 chk("R3 no trunc when off", 32'(hs_trunc[0]), 0);
        oc_flag[0] = 1'b0;
        clear_pulse();
        chk("R5 clear restarts hs", 32'(hs_en[0]), 1);
        chk("R5 clear restarts ss", 32'(ss_req[0]), 1);
        chk("R8 clear drops flag", 32'(flt_sts[0]), 0);
        ssdone(0);
        cyc(0, 1, 0); cyc(0, 1, 0);
        chk("R5 fresh count", 32'(hs_en[0]), 1);
        cyc(0, 1, 0);
        chk("R5 relatch", 32'(hs_en[0]), 0);
        @(negedge clk); chan_en[0] = 1'b0;
        @(negedge clk); chan_en[0] = 1'b1;
        @(negedge clk);
        chk("R5 toggle restarts hs", 32'(hs_en[0]), 1);
        chk("R5 toggle restarts ss", 32'(ss_req[0]), 1);
    endtask

    task automatic t_hiccup();
        resp_hiccup[0] = 1'b1;
        bring_up(0);
        cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
        chk("R6 trip gates off", 32'(hs_en[0]), 0);
        chk("R6 ss_req in hiccup", 32'(ss_req[0]), 1);
        for (int i = 0; i < 6; i++) ssdone(0);
        chk("R6 six periods still off", 32'(hs_en[0]), 0);
        ssdone(0);
        chk("R6 seventh restarts", 32'(hs_en[0]), 1);
        chk("R6 restart ss_req", 32'(ss_req[0]), 1);
        cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
        chk("R7 persists retrips", 32'(hs_en[0]), 0);
        for (int i = 0; i < 7; i++) ssdone(0);
        chk("R7 second restart", 32'(hs_en[0]), 1);
        ssdone(0);
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R7 cleared keeps run hs", 32'(hs_en[0]), 1);
        chk("R7 cleared run ss_req", 32'(ss_req[0]), 0);
        chk("R8 sticky after retry", 32'(flt_sts[0]), 1);
        clear_pulse();
        chk("R8 clear after retry", 32'(flt_sts[0]), 0);
    endtask

    task automatic t_same_cycle();
        resp_hiccup[0] = 1'b1;
        bring_up(0);
        cyc(0, 1, 0); cyc(0, 1, 0);
        @(negedge clk); cyc_stb[0] = 1'b1; oc_flag[0] = 1'b1; clr_flt = 1'b1;
        @(negedge clk); cyc_stb[0] = 1'b0; oc_flag[0] = 1'b0; clr_flt = 1'b0;
        chk("R8 set beats clear", 32'(flt_sts[0]), 1);
        chk("R4 gates off with clear", 32'(hs_en[0]), 0);
        clear_pulse();
        chk("R8 lone clear", 32'(flt_sts[0]), 0);
    endtask

    task automatic t_warn();
        bring_up(0);
        cyc(0, 0, 1);
        chk("R9 warn set", 32'(warn_sts[0]), 1);
        chk("R9 gates stay", 32'(hs_en[0]), 1);
        chk("R9 no fault", 32'(flt_sts[0]), 0);
        clear_pulse();
        chk("R9 warn cleared", 32'(warn_sts[0]), 0);
    endtask

    task automatic t_two_phase();
        oc_lim_in = 16'hB3_5A; warn_lim_in = 16'h91_2C;
        two_phase = 1'b0;
        #1 chk("R10 dual fault", 32'(oc_lim_out), 32'hB35A);
        chk("R10 dual warn", 32'(warn_lim_out), 32'h912C);
        two_phase = 1'b1;
        #1 chk("R10 shared fault", 32'(oc_lim_out), 32'h5A5A);
        chk("R10 shared warn", 32'(warn_lim_out), 32'h2C2C);
        two_phase = 1'b0;
    endtask

    task automatic t_disable();
        bring_up(0);
        @(negedge clk); chan_en[0] = 1'b0;
        @(negedge clk);
        chk("R11 off from run", 32'(hs_en[0]), 0);
        resp_hiccup[0] = 1'b1;
        bring_up(0);
        cyc(0, 1, 0); cyc(0, 1, 0); cyc(0, 1, 0);
        @(negedge clk); chan_en[0] = 1'b0;
        @(negedge clk);
        chk("R11 off from hiccup", 32'(ss_req[0]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_startup();
        t_trunc();
        t_latch();
        t_hiccup();
        t_same_cycle();
        t_warn();
        t_two_phase();
        t_disable();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule